// File: doc/BRIEF.md
# Background Integer Multiply/Divide Unit

This block is a 32-bit integer multiply and divide engine that sits beside a processor pipeline and finishes its work in the background. The pipeline hands it one operation at a time over a simple command port. The operations are signed or unsigned multiply, multiply-accumulate, multiply-subtract, and signed or unsigned divide. Every result lands in a 64-bit pair of result registers, called HI (upper word) and LO (lower word). Both are always visible on output ports.

Multiplies go through a 32x16 array. When the second operand fits in 16 bits, one pass is enough and a new multiply can be accepted on every clock. A full-width second operand needs a low pass and a high pass, so the unit stalls new commands for one cycle.

Divides use an iterative restoring algorithm. Before iterating, it strips the whole bytes of the dividend that only repeat its sign, so small dividends finish sooner. The divide time therefore depends on the data. Software-visible timing is fully determined by the operands. A `busy` flag tells the issuer when a command would be refused. A one-cycle `done` pulse marks each update of HI/LO.

Top module: `mdu_core`

## Requirements
- R1: After reset, HI and LO read zero and both `busy` and `done` are low.
- R2: `op_code[2:1]` selects the operation and `op_code[0]=1` selects unsigned operands. The operation codes are 00 multiply, 01 multiply-accumulate, 10 multiply-subtract, 11 divide. An issue is a rising edge with `op_valid` high and `busy` low. A multiply counts as narrow when its second operand lies in [-32768, 32767] for signed or below 65536 for unsigned. A narrow multiply updates HI/LO at the first rising edge after its issue edge, leaves `busy` low, and so allows a new issue on every edge.
- R3: A wide (not narrow) multiply raises `busy` for exactly the one cycle after its issue edge. It updates HI/LO at the second edge after issue, and a new command is accepted at that same edge.
- R4: Signed variants sign-extend both operands and unsigned variants zero-extend them. HI:LO then holds the 64-bit product, with HI as the upper word.
- R5: Multiply-accumulate adds the 64-bit product to HI:LO, and multiply-subtract takes it away, both modulo 2^64. Back-to-back accumulates see each other's results.
- R6: A divide places the quotient in LO and the remainder in HI. For signed divide the quotient truncates toward zero and the remainder carries the dividend's sign. Dividing -2^31 by -1 gives LO=0x80000000 and HI=0.
- R7: The divide latency L is counted in rising edges from the issue edge to the edge that writes HI/LO, with L = max(11, 34 - 8*s). Here s (0 to 3) is the number of leading dividend bytes that are pure sign extension. For signed operands, s is the largest k for which the dividend fits in 32-8k bits signed. For unsigned operands, the dividend must fit in 32-8k bits unsigned. `busy` stays high from the issue edge until that write edge.
- R8: A divide by zero takes the same latency as R7 and gives LO = 0xFFFFFFFF and HI = the dividend.
- R9: `op_valid` while `busy` is high is ignored. HI/LO and the following `done` pulses are unaffected, and only one operation ever writes HI/LO at a given edge.
- R10: `done` is high for exactly the one cycle after each edge that writes HI/LO. HI and LO change at no other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Command present |
| op_code | input | 3 | Operation select, encoding in R2 |
| op_a | input | 32 | First operand (dividend for divides) |
| op_b | input | 32 | Second operand (divisor for divides) |
| busy | output | 1 | High when a command would be refused |
| done | output | 1 | One-cycle pulse after each HI/LO update |
| hi_out | output | 32 | HI result register |
| lo_out | output | 32 | LO result register |

## Verification
The assertions assume the issuer never relies on a command being taken while `busy` is high. They also assume that any value it holds on `op_a`/`op_b` during an issue edge is the value it means. They take the 32-bit operand width as fixed when they recompute narrowness and divide latency. The bench drives every command at the falling edge and waits for `busy` to drop before each real issue. It pushes stray commands only in a window that is provably inside a running divide, so every accepted operation is one the scoreboard predicted.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  localparam int XLEN      = 32;
  localparam int HALF      = XLEN / 2;
  localparam int GRP       = 8;
  localparam int MAX_SKIP  = XLEN / GRP - 1;
  localparam int SKIP_W    = $clog2(MAX_SKIP + 1);
  localparam int CNT_W     = $clog2(XLEN + 1);
  localparam int DIV_OVH   = 2;
  localparam int MIN_DIV_L = 11;

  typedef enum logic [1:0] {
    K_MUL  = 2'b00,
    K_MAC  = 2'b01,
    K_MSUB = 2'b10,
    K_DIV  = 2'b11
  } mdu_kind_e;

  function automatic mdu_kind_e op_kind(input logic [2:0] code);
    return mdu_kind_e'(code[2:1]);
  endfunction

  function automatic logic op_signed(input logic [2:0] code);
    return ~code[0];
  endfunction

  // second operand reachable by one 32x16 pass
  function automatic logic fits_half(input logic [XLEN-1:0] v, input logic sgn);
    logic [XLEN-HALF:0] top_s;
    logic [XLEN-HALF-1:0] top_u;
    top_s = v[XLEN-1:HALF-1];
    top_u = v[XLEN-1:HALF];
    return sgn ? ((&top_s) | ~(|top_s)) : ~(|top_u);
  endfunction

  function automatic logic [XLEN-1:0] mag(input logic [XLEN-1:0] v, input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [CNT_W-1:0] div_iters(input logic [SKIP_W-1:0] skip);
    return CNT_W'(XLEN - GRP * int'(skip));
  endfunction

  function automatic logic [CNT_W-1:0] div_pad(input logic [SKIP_W-1:0] skip);
    int base;
    base = XLEN - GRP * int'(skip) + DIV_OVH;
    return (base < MIN_DIV_L) ? CNT_W'(MIN_DIV_L - base) : '0;
  endfunction

endpackage

// File: rtl/mdu_mul_array.sv
module mdu_mul_array
  import mdu_pkg::*;
(
  input  logic signed [XLEN:0]     a_x,
  input  logic signed [HALF:0]     b_x,
  output logic        [2*XLEN-1:0] prod
);
  localparam int PW = XLEN + HALF + 2;

  logic signed [PW-1:0] full;

  always_comb begin
    full = a_x * b_x;
    prod = {{(2*XLEN-PW){full[PW-1]}}, full};
  end
endmodule

// File: rtl/mdu_mul_unit.sv
module mdu_mul_unit
  import mdu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  mdu_kind_e         kind,
  input  logic              sgn,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  input  logic [2*XLEN-1:0] acc,
  output logic              wr,
  output logic [2*XLEN-1:0] wr_val,
  output logic              busy
);
  typedef enum logic [1:0] {P_ONE, P_LOW, P_HIGH} pass_e;

  logic              v_q;
  pass_e             pass_q;
  logic [XLEN-1:0]   a_q, b_q;
  logic              sgn_q;
  mdu_kind_e         kind_q;
  logic [2*XLEN-1:0] partial_q;

  logic signed [XLEN:0] arr_a;
  logic signed [HALF:0] arr_b;
  logic [2*XLEN-1:0]    arr_p;
  logic [2*XLEN-1:0]    product;

  always_comb begin
    arr_a = {sgn_q & a_q[XLEN-1], a_q};
    unique case (pass_q)
      P_LOW:   arr_b = {1'b0, b_q[HALF-1:0]};
      P_HIGH:  arr_b = {sgn_q & b_q[XLEN-1], b_q[XLEN-1:HALF]};
      default: arr_b = {sgn_q & b_q[HALF-1], b_q[HALF-1:0]};
    endcase
  end

  mdu_mul_array u_array (
    .a_x  (arr_a),
    .b_x  (arr_b),
    .prod (arr_p)
  );

  always_comb begin
    product = (pass_q == P_HIGH) ? (partial_q + (arr_p << HALF)) : arr_p;
    unique case (kind_q)
      K_MAC:   wr_val = acc + product;
      K_MSUB:  wr_val = acc - product;
      default: wr_val = product;
    endcase
    wr   = v_q && (pass_q != P_LOW);
    busy = v_q && (pass_q == P_LOW);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q       <= 1'b0;
      pass_q    <= P_ONE;
      a_q       <= '0;
      b_q       <= '0;
      sgn_q     <= 1'b0;
      kind_q    <= K_MUL;
      partial_q <= '0;
    end else if (issue) begin
      v_q    <= 1'b1;
      pass_q <= fits_half(b, sgn) ? P_ONE : P_LOW;
      a_q    <= a;
      b_q    <= b;
      sgn_q  <= sgn;
      kind_q <= kind;
    end else if (v_q && pass_q == P_LOW) begin
      pass_q    <= P_HIGH;
      partial_q <= arr_p;
    end else begin
      v_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mdu_sign_skip.sv
module mdu_sign_skip
  import mdu_pkg::*;
(
  input  logic [XLEN-1:0]   val,
  input  logic              sgn,
  output logic [SKIP_W-1:0] skip
);
  logic [MAX_SKIP:1] grp_ok;

  for (genvar k = 1; k <= MAX_SKIP; k++) begin : g_grp
    logic [GRP*k:0]   top_s;
    logic [GRP*k-1:0] top_u;
    assign top_s     = val[XLEN-1 -: GRP*k+1];
    assign top_u     = val[XLEN-1 -: GRP*k];
    assign grp_ok[k] = sgn ? ((&top_s) | ~(|top_s)) : ~(|top_u);
  end

  // groups nest, so the deepest passing group is the count
  always_comb begin
    skip = '0;
    for (int k = 1; k <= MAX_SKIP; k++)
      if (grp_ok[k]) skip = SKIP_W'(k);
  end
endmodule

// File: rtl/mdu_div_unit.sv
module mdu_div_unit
  import mdu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic            sgn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            wr,
  output logic [XLEN-1:0] hi,
  output logic [XLEN-1:0] lo,
  output logic            busy
);
  typedef enum logic [2:0] {D_IDLE, D_PREP, D_ITER, D_PAD, D_FIX} dstate_e;

  dstate_e          st_q;
  logic [XLEN-1:0]  a_q, b_q, dvd_q, rem_q, dvs_q;
  logic             sgn_q, neg_q_q, neg_r_q, dz_q;
  logic [CNT_W-1:0] cnt_q, pad_q;

  logic [SKIP_W-1:0] skip;
  logic              a_neg, b_neg;
  logic [XLEN:0]     trial;
  logic              ge;
  logic [XLEN-1:0]   diff;

  mdu_sign_skip u_skip (
    .val  (a_q),
    .sgn  (sgn_q),
    .skip (skip)
  );

  always_comb begin
    a_neg = sgn_q & a_q[XLEN-1];
    b_neg = sgn_q & b_q[XLEN-1];
    trial = {rem_q, dvd_q[XLEN-1]};
    ge    = trial >= {1'b0, dvs_q};
    diff  = trial[XLEN-1:0] - dvs_q;
    wr    = (st_q == D_FIX);
    busy  = (st_q != D_IDLE);
    lo    = dz_q ? '1  : mag(dvd_q, neg_q_q);
    hi    = dz_q ? a_q : mag(rem_q, neg_r_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= D_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      sgn_q   <= 1'b0;
      dvd_q   <= '0;
      rem_q   <= '0;
      dvs_q   <= '0;
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
      dz_q    <= 1'b0;
      cnt_q   <= '0;
      pad_q   <= '0;
    end else begin
      unique case (st_q)
        D_IDLE: if (issue) begin
          st_q  <= D_PREP;
          a_q   <= a;
          b_q   <= b;
          sgn_q <= sgn;
        end
        D_PREP: begin
          dvd_q   <= mag(a_q, a_neg) << (GRP * int'(skip));
          dvs_q   <= mag(b_q, b_neg);
          rem_q   <= '0;
          cnt_q   <= div_iters(skip);
          pad_q   <= div_pad(skip);
          neg_q_q <= a_neg ^ b_neg;
          neg_r_q <= a_neg;
          dz_q    <= (b_q == '0);
          st_q    <= D_ITER;
        end
        D_ITER: begin
          rem_q <= ge ? diff : trial[XLEN-1:0];
          dvd_q <= {dvd_q[XLEN-2:0], ge};
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) st_q <= (pad_q != '0) ? D_PAD : D_FIX;
        end
        D_PAD: begin
          pad_q <= pad_q - 1'b1;
          if (pad_q == CNT_W'(1)) st_q <= D_FIX;
        end
        default: st_q <= D_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdu_core.sv
module mdu_core
  import mdu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_code,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] hi_out,
  output logic [XLEN-1:0] lo_out
);
  mdu_kind_e         kind;
  logic              sgn, issue, mul_issue, div_issue;
  logic              mul_wr, div_wr, mul_busy, div_busy;
  logic [2*XLEN-1:0] mul_val, hilo_q;
  logic [XLEN-1:0]   div_hi, div_lo;

  always_comb begin
    kind      = op_kind(op_code);
    sgn       = op_signed(op_code);
    busy      = mul_busy | div_busy;
    issue     = op_valid && !busy;
    mul_issue = issue && (kind != K_DIV);
    div_issue = issue && (kind == K_DIV);
    hi_out    = hilo_q[2*XLEN-1:XLEN];
    lo_out    = hilo_q[XLEN-1:0];
  end

  mdu_mul_unit u_mul (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue  (mul_issue),
    .kind   (kind),
    .sgn    (sgn),
    .a      (op_a),
    .b      (op_b),
    .acc    (hilo_q),
    .wr     (mul_wr),
    .wr_val (mul_val),
    .busy   (mul_busy)
  );

  mdu_div_unit u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .issue (div_issue),
    .sgn   (sgn),
    .a     (op_a),
    .b     (op_b),
    .wr    (div_wr),
    .hi    (div_hi),
    .lo    (div_lo),
    .busy  (div_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hilo_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= mul_wr | div_wr;
      if (mul_wr)      hilo_q <= mul_val;
      else if (div_wr) hilo_q <= {div_hi, div_lo};
    end
  end
endmodule

// File: rtl/mdu_core_chk.sv
module mdu_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_code,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        busy,
  input logic        done,
  input logic [31:0] hi_out,
  input logic [31:0] lo_out,
  input logic        mul_wr,
  input logic        div_wr
);
  logic div_iss, mul_iss, narrow_b, wr_any;
  logic wide_d1, div_pend;
  logic [7:0] lat_cnt, exp_lat;

  function automatic logic [7:0] ref_lat(input logic [31:0] a, input logic uns);
    int sk;
    longint v;
    v = longint'($signed(a));
    if (uns) sk = (a < 32'h100) ? 3 : (a < 32'h10000) ? 2 : (a < 32'h1000000) ? 1 : 0;
    else     sk = (v >= -128 && v <= 127) ? 3 : (v >= -32768 && v <= 32767) ? 2 :
                  (v >= -8388608 && v <= 8388607) ? 1 : 0;
    return (34 - 8*sk < 11) ? 8'd11 : 8'(34 - 8*sk);
  endfunction

  always_comb begin
    div_iss  = op_valid && !busy && (op_code[2:1] == 2'b11);
    mul_iss  = op_valid && !busy && (op_code[2:1] != 2'b11);
    narrow_b = op_code[0] ? (op_b < 32'h10000)
                          : (longint'($signed(op_b)) >= -32768 && longint'($signed(op_b)) <= 32767);
    wr_any   = mul_wr | div_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wide_d1  <= 1'b0;
      div_pend <= 1'b0;
      lat_cnt  <= '0;
      exp_lat  <= '0;
    end else begin
      wide_d1 <= mul_iss && !narrow_b;
      if (div_iss) begin
        div_pend <= 1'b1;
        lat_cnt  <= 8'd1;
        exp_lat  <= ref_lat(op_a, op_code[0]);
      end else begin
        if (div_wr) div_pend <= 1'b0;
        if (lat_cnt != 8'hff) lat_cnt <= lat_cnt + 8'd1;
      end
    end
  end

  a_r2_narrow_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_iss && narrow_b) |=> (!busy && mul_wr));
  a_r3_wide_first_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_iss && !narrow_b) |=> (busy && !mul_wr));
  a_r3_wide_second_pass: assert property (@(posedge clk) disable iff (!rst_n)
    wide_d1 |=> mul_wr);
  a_r7_div_latency: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |-> (div_pend && lat_cnt == exp_lat));
  a_r7_busy_while_div: assert property (@(posedge clk) disable iff (!rst_n)
    (div_pend && !div_wr) |-> busy);
  a_r9_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(mul_wr && div_wr));
  a_r10_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> done);
  a_r10_quiet_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any |=> (!done && $stable(hi_out) && $stable(lo_out)));
endmodule

bind mdu_core mdu_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_code  (op_code),
  .op_a     (op_a),
  .op_b     (op_b),
  .busy     (busy),
  .done     (done),
  .hi_out   (hi_out),
  .lo_out   (lo_out),
  .mul_wr   (mul_wr),
  .div_wr   (div_wr)
);

// File: tb/mdu_core_tb.sv
`timescale 1ns/1ps
module mdu_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        busy, done;
  logic [31:0] hi_out, lo_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [63:0] model = '0;
  logic [31:0] rng = 32'h1badb002;

  typedef struct {
    logic [31:0] hi;
    logic [31:0] lo;
    int          lat;
    int          icyc;
    string       tag;
  } exp_t;
  exp_t sb[$];
  exp_t mon_e;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdu_core u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
    .hi_out(hi_out), .lo_out(lo_out)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, expv);
    end
  endtask

  function automatic int lat_of(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    longint va, vb;
    int sk, l;
    va = op[0] ? longint'({32'b0, a}) : longint'($signed(a));
    vb = op[0] ? longint'({32'b0, b}) : longint'($signed(b));
    if (op[2:1] != 2'b11)
      return (vb >= -32768 && vb < 65536 && (op[0] || vb <= 32767)) ? 1 : 2;
    sk = 0;
    if (va >= -8388608 && va < 16777216 && (op[0] || va <= 8388607)) sk = 1;
    if (va >= -32768 && va < 65536 && (op[0] || va <= 32767)) sk = 2;
    if (va >= -128 && va < 256 && (op[0] || va <= 127)) sk = 3;
    l = 34 - 8*sk;
    return (l < 11) ? 11 : l;
  endfunction

  task automatic issue_op(input logic [2:0] op, input logic [31:0] a,
                          input logic [31:0] b, input string tag);
    exp_t e;
    longint va, vb, q, r;
    logic [63:0] p;
    while (busy) @(negedge clk);
    va = op[0] ? longint'({32'b0, a}) : longint'($signed(a));
    vb = op[0] ? longint'({32'b0, b}) : longint'($signed(b));
    p  = 64'(va * vb);
    case (op[2:1])
      2'b00: model = p;
      2'b01: model = model + p;
      2'b10: model = model - p;
      default: begin
        if (b == 32'h0) model = {a, 32'hffffffff};
        else begin
          q = va / vb;
          r = va % vb;
          model = {r[31:0], q[31:0]};
        end
      end
    endcase
    e.hi = model[63:32];
    e.lo = model[31:0];
    e.lat = lat_of(op, a, b);
    e.icyc = cyc + 1;
    e.tag = tag;
    sb.push_back(e);
    op_valid = 1'b1; op_code = op; op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // monitor: pop expected results as HI/LO updates are announced
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R10", "unexpected done", {hi_out, lo_out}, 64'h0);
      end else begin
        mon_e = sb.pop_front();
        chk({hi_out, lo_out} == {mon_e.hi, mon_e.lo}, mon_e.tag, "hi:lo",
            {hi_out, lo_out}, {mon_e.hi, mon_e.lo});
        chk(cyc - mon_e.icyc == mon_e.lat, (mon_e.lat > 2) ? "R7" : "R2/R3 latency",
            "latency", 64'(cyc - mon_e.icyc), 64'(mon_e.lat));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=%0d exp=0", sb.size());
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0 && done == 1'b0, "R1", "flags", {62'b0, busy, done}, 64'h0);
    chk({hi_out, lo_out} == 64'h0, "R1", "hi:lo", {hi_out, lo_out}, 64'h0);

    // R2 R4: narrow multiplies, signed and unsigned
    issue_op(3'b000, 32'd7, 32'hfffffffd, "R4");
    chk(busy == 1'b0, "R2", "busy after narrow", {63'b0, busy}, 64'h0);
    issue_op(3'b001, 32'hffffffff, 32'h0000ffff, "R4");
    // R2 R5: back-to-back accumulate chain, one issue per clock
    issue_op(3'b010, 32'd1000, 32'd1000, "R5");
    issue_op(3'b011, 32'hffffffff, 32'd2, "R5");
    issue_op(3'b100, 32'h80000000, 32'h00007fff, "R5");
    chk(busy == 1'b0, "R2", "busy in chain", {63'b0, busy}, 64'h0);

    // R3 R4: wide multiplies
    issue_op(3'b000, 32'h12345678, 32'h9abcdef0, "R3");
    chk(busy == 1'b1, "R3", "busy after wide", {63'b0, busy}, 64'h1);
    issue_op(3'b001, 32'h12345678, 32'h9abcdef0, "R4");
    issue_op(3'b101, 32'hdeadbeef, 32'h00010000, "R5");
    issue_op(3'b010, 32'h80000000, 32'h80000000, "R5");

    // R6 R7: divides over each sign/byte case
    issue_op(3'b110, 32'd100, 32'd7, "R6");
    issue_op(3'b110, -32'sd100, 32'd7, "R6");
    issue_op(3'b110, 32'd100, -32'sd7, "R6");
    issue_op(3'b110, -32'sd100, -32'sd7, "R6");
    issue_op(3'b110, 32'h80000000, 32'hffffffff, "R6");
    issue_op(3'b111, 32'hffffffff, 32'd3, "R6");
    issue_op(3'b111, 32'h00000080, 32'd5, "R7");
    issue_op(3'b110, 32'h00000080, 32'd5, "R7");
    issue_op(3'b110, -32'sd129, 32'd4, "R7");
    issue_op(3'b111, 32'h00001234, 32'd9, "R7");
    issue_op(3'b111, 32'h00123456, 32'd9, "R7");
    issue_op(3'b111, 32'h12345678, 32'd9, "R7");
    issue_op(3'b110, -32'sd8388608, 32'd3, "R7");

    // R8: divide by zero
    issue_op(3'b110, -32'sd5, 32'd0, "R8");
    issue_op(3'b111, 32'h89abcdef, 32'd0, "R8");

    // R9: stray commands during a divide are ignored
    issue_op(3'b110, 32'd1000, 32'd7, "R9");
    for (int i = 0; i < 8; i++) begin
      chk(busy == 1'b1, "R9", "busy during divide", {63'b0, busy}, 64'h1);
      op_valid = 1'b1; op_code = 3'b001; op_a = 32'd3; op_b = 32'd3;
      @(negedge clk);
    end
    op_valid = 1'b0;
    // R5: accumulate on top of a divide result
    issue_op(3'b011, 32'd2, 32'd3, "R5");

    // mixed random traffic
    for (int i = 0; i < 60; i++) begin
      logic [31:0] ra, rb;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      ra = rng;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      rb = rng;
      if (rng[3]) rb = {{16{rb[15]}}, rb[15:0]};
      if (rng[5:4] == 2'b00) ra = {{24{ra[7]}}, ra[7:0]};
      issue_op(rng[30:28], ra, rb, "R4/R5/R6 mix");
    end

    for (int i = 0; i < 100 && sb.size() != 0; i++) @(negedge clk);
    chk(sb.size() == 0, "R10", "results outstanding", 64'(sb.size()), 64'h0);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done idle", {63'b0, done}, 64'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule